// File: doc/BRIEF.md
# Video Capture Frame-Sync Event Gate

This block follows the vertical timing of an incoming interlaced digital video stream and decides when the capture path may raise DMA requests, when field and frame status may be recorded, and when field, frame and vertical interrupts may fire. Timing arrives either as decoded end-of-active-video strobes carrying the field and vertical-blank flags from the embedded timing codes, or as external vertical-sync and field-id levels. A vertical-blank start marks the end of a field's active region. A vertical-blank end marks the start of the next field's active lines.

Software stops capture with a block control bit. While it is set, the block drives a FIFO flush, withholds DMA enable, freezes status and silences interrupts. When the bit is released, DMA stays off through the remainder of the current field and resumes only when a field-1 active region next begins. A polarity bit sets which raw field flag value counts as field 1. A select bit sets the blanking edge that resets the 12-bit line counter.

Top module: `vcap_sync_gate`

## Requirements
- R1: One cycle after `blk_cap` is sampled high, `fifo_flush` is high and `dma_en` is low; both hold for as long as the bit stays set.
- R2: While `blk_cap` is high, no bit of `sts` (bit 0 field-1 complete, bit 1 field-2 complete, bit 2 frame complete) becomes set.
- R3: While `blk_cap` is high, `fld_irq`, `frm_irq` and `vert_irq` stay low.
- R4: After `blk_cap` falls, `dma_en` stays low until the first blank-end event whose mapped field is field 1, and rises in the cycle after that event; out of reset the block waits the same way.
- R5: The mapped field is the raw field flag XOR `fld_inv`: a mapped 0 is field 1 and a mapped 1 is field 2.
- R6: At a blank-start event that ends a field whose start was seen, the field's status bit is set and `fld_irq` pulses for one cycle; when that field is field 2, `sts[2]` is also set and `frm_irq` pulses.
- R7: Status bits are sticky and are cleared by a one in the matching bit of `sts_clr`; a set and a clear of the same bit in the same cycle leave the bit set.
- R8: `vcount` increments by one on each `eav_stb` and saturates at 4095.
- R9: `vcount` becomes 0 on a blank-start event when `vrst_sel` is 0, and on a blank-end event when it is 1.
- R10: `flush_stb` is high for exactly one cycle following the rise of `blk_cap`.
- R11: With `src_ext` high, a rise of `ext_vs` is a blank-start event, a fall is a blank-end event, and `ext_fld` is the raw field flag. With `src_ext` low, events come from `v_bit` changes seen at `eav_stb`, with `f_bit` as the raw flag.
- R12: `vert_irq` pulses for one cycle on every blank-start event while unblocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_ext | input | 1 | 1: external sync levels, 0: embedded flags |
| eav_stb | input | 1 | End-of-active-video strobe, one per line |
| f_bit | input | 1 | Embedded field flag, valid with eav_stb |
| v_bit | input | 1 | Embedded vertical-blank flag, valid with eav_stb |
| ext_vs | input | 1 | External vertical sync level (high in blanking) |
| ext_fld | input | 1 | External field-id level |
| blk_cap | input | 1 | Block capture control |
| fld_inv | input | 1 | Field polarity invert |
| vrst_sel | input | 1 | Line counter reset edge select |
| sts_clr | input | 3 | Write-one-to-clear strobes for sts |
| fifo_flush | output | 1 | FIFO flush level while blocked |
| flush_stb | output | 1 | One-cycle pulse when blocking begins |
| dma_en | output | 1 | DMA event enable |
| sts | output | 3 | Sticky field-1 / field-2 / frame complete |
| fld_irq | output | 1 | Field-complete interrupt pulse |
| frm_irq | output | 1 | Frame-complete interrupt pulse |
| vert_irq | output | 1 | Vertical interrupt pulse |
| vcount | output | 12 | Vertical line counter |

## Verification
Each output comes from a single register stage. A strobe, sync edge, block change or clear that is sampled at one rising edge is visible just after that edge, and an interrupt pulse lasts only that one cycle. The bench changes inputs on falling edges and reads the outputs on the next falling edge, half a cycle after the edge that sampled them. Each pulse is checked in that window, and an irq monitor covers every cycle of a blocked stretch. For the delayed re-enable, the bench confirms `dma_en` is still low after an intervening field-2 start and high right after the next field-1 start.

// File: rtl/vsg_pkg.sv
package vsg_pkg;
    localparam int STS_W   = 3;
    localparam int STS_F1  = 0;
    localparam int STS_F2  = 1;
    localparam int STS_FRM = 2;

    typedef enum logic [1:0] {
        GS_WAIT    = 2'd0,
        GS_RUN     = 2'd1,
        GS_BLOCKED = 2'd2
    } gate_st_e;

    typedef struct packed {
        logic blank_start;
        logic blank_end;
        logic fld2;
    } vtm_evt_t;
endpackage

// File: rtl/vsg_timing.sv
module vsg_timing
    import vsg_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     src_ext,
    input  logic     eav_stb,
    input  logic     f_bit,
    input  logic     v_bit,
    input  logic     ext_vs,
    input  logic     ext_fld,
    input  logic     fld_inv,
    output vtm_evt_t evt_o
);
    typedef struct packed {
        logic v_prev;
        logic vs_prev;
    } tm_reg_t;

    tm_reg_t  r_d, r_q;
    vtm_evt_t evt_c;
    logic     raw_fld;

    always_comb begin
        r_d         = r_q;
        r_d.vs_prev = ext_vs;
        evt_c       = '0;
        raw_fld     = 1'b0;
        if (src_ext) begin
            raw_fld           = ext_fld;
            evt_c.blank_start = ext_vs & ~r_q.vs_prev;
            evt_c.blank_end   = ~ext_vs & r_q.vs_prev;
        end else begin
            raw_fld = f_bit;
            if (eav_stb) begin
                r_d.v_prev        = v_bit;
                evt_c.blank_start = v_bit & ~r_q.v_prev;
                evt_c.blank_end   = ~v_bit & r_q.v_prev;
            end
        end
        evt_c.fld2 = raw_fld ^ fld_inv;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign evt_o = evt_c;

    AST_EVT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(evt_o.blank_start && evt_o.blank_end)); // R11
endmodule

// File: rtl/vsg_vcount.sv
module vsg_vcount
    import vsg_pkg::*;
#(
    parameter int VCNT_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              eav_stb,
    input  logic              vrst_sel,
    input  vtm_evt_t          evt_i,
    output logic [VCNT_W-1:0] vcount_o
);
    localparam logic [VCNT_W-1:0] CNT_MAX = {VCNT_W{1'b1}};

    typedef struct packed {
        logic [VCNT_W-1:0] cnt;
    } vc_reg_t;

    vc_reg_t r_d, r_q;
    logic    rst_evt;

    always_comb begin
        r_d     = r_q;
        rst_evt = vrst_sel ? evt_i.blank_end : evt_i.blank_start;
        if (rst_evt)
            r_d.cnt = '0;
        else if (eav_stb && (r_q.cnt != CNT_MAX))
            r_d.cnt = r_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign vcount_o = r_q.cnt;

    AST_VCNT_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        (vcount_o == CNT_MAX && eav_stb && !rst_evt) |=> (vcount_o == CNT_MAX)); // R8
    AST_VCNT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rst_evt |=> (vcount_o == '0)); // R9
endmodule

// File: rtl/vsg_gate.sv
module vsg_gate
    import vsg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             blk_cap,
    input  logic [STS_W-1:0] sts_clr,
    input  vtm_evt_t         evt_i,
    output logic             fifo_flush_o,
    output logic             flush_stb_o,
    output logic             dma_en_o,
    output logic [STS_W-1:0] sts_o,
    output logic             fld_irq_o,
    output logic             frm_irq_o,
    output logic             vert_irq_o
);
    typedef struct packed {
        gate_st_e         st;
        logic             fld2;
        logic             fvld;
        logic [STS_W-1:0] sts;
        logic             fld_irq;
        logic             frm_irq;
        logic             vert_irq;
        logic             flush;
        logic             flush_stb;
    } gate_reg_t;

    gate_reg_t r_d, r_q;

    always_comb begin
        r_d           = r_q;
        r_d.fld_irq   = 1'b0;
        r_d.frm_irq   = 1'b0;
        r_d.vert_irq  = 1'b0;
        r_d.flush     = blk_cap;
        r_d.flush_stb = blk_cap & ~r_q.flush;
        r_d.sts       = r_q.sts & ~sts_clr;

        if (evt_i.blank_end) begin
            r_d.fld2 = evt_i.fld2;
            r_d.fvld = 1'b1;
        end

        if (evt_i.blank_start) begin
            r_d.fvld = 1'b0;
            if (!blk_cap) begin
                r_d.vert_irq = 1'b1;
                if (r_q.fvld) begin
                    r_d.fld_irq = 1'b1;
                    if (r_q.fld2) begin
                        r_d.sts[STS_F2]  = 1'b1;
                        r_d.sts[STS_FRM] = 1'b1;
                        r_d.frm_irq      = 1'b1;
                    end else begin
                        r_d.sts[STS_F1]  = 1'b1;
                    end
                end
            end
        end

        if (blk_cap) begin
            r_d.st = GS_BLOCKED;
        end else begin
            unique case (r_q.st)
                GS_BLOCKED: r_d.st = GS_WAIT;
                GS_WAIT:    if (evt_i.blank_end && !evt_i.fld2) r_d.st = GS_RUN;
                default:    r_d.st = r_q.st;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign fifo_flush_o = r_q.flush;
    assign flush_stb_o  = r_q.flush_stb;
    assign dma_en_o     = (r_q.st == GS_RUN);
    assign sts_o        = r_q.sts;
    assign fld_irq_o    = r_q.fld_irq;
    assign frm_irq_o    = r_q.frm_irq;
    assign vert_irq_o   = r_q.vert_irq;

    AST_FLUSH_NO_DMA: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_flush_o |-> !dma_en_o); // R1
    AST_NO_STS_SET: assert property (@(posedge clk) disable iff (!rst_n)
        blk_cap |=> ((sts_o & ~$past(sts_o)) == '0)); // R2
    AST_NO_IRQ_BLK: assert property (@(posedge clk) disable iff (!rst_n)
        blk_cap |=> !(fld_irq_o || frm_irq_o || vert_irq_o)); // R3
    AST_EN_AT_F1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dma_en_o) |-> $past(evt_i.blank_end && !evt_i.fld2 && !blk_cap)); // R4
    AST_FRM_WITH_FLD: assert property (@(posedge clk) disable iff (!rst_n)
        frm_irq_o |-> fld_irq_o); // R6
    AST_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        flush_stb_o |=> !flush_stb_o); // R10
endmodule

// File: rtl/vcap_sync_gate.sv
module vcap_sync_gate
    import vsg_pkg::*;
#(
    parameter int VCNT_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              src_ext,
    input  logic              eav_stb,
    input  logic              f_bit,
    input  logic              v_bit,
    input  logic              ext_vs,
    input  logic              ext_fld,
    input  logic              blk_cap,
    input  logic              fld_inv,
    input  logic              vrst_sel,
    input  logic [STS_W-1:0]  sts_clr,
    output logic              fifo_flush,
    output logic              flush_stb,
    output logic              dma_en,
    output logic [STS_W-1:0]  sts,
    output logic              fld_irq,
    output logic              frm_irq,
    output logic              vert_irq,
    output logic [VCNT_W-1:0] vcount
);
    vtm_evt_t evt;

    vsg_timing u_timing (
        .clk     (clk),
        .rst_n   (rst_n),
        .src_ext (src_ext),
        .eav_stb (eav_stb),
        .f_bit   (f_bit),
        .v_bit   (v_bit),
        .ext_vs  (ext_vs),
        .ext_fld (ext_fld),
        .fld_inv (fld_inv),
        .evt_o   (evt)
    );

    vsg_vcount #(.VCNT_W(VCNT_W)) u_vcount (
        .clk      (clk),
        .rst_n    (rst_n),
        .eav_stb  (eav_stb),
        .vrst_sel (vrst_sel),
        .evt_i    (evt),
        .vcount_o (vcount)
    );

    vsg_gate u_gate (
        .clk          (clk),
        .rst_n        (rst_n),
        .blk_cap      (blk_cap),
        .sts_clr      (sts_clr),
        .evt_i        (evt),
        .fifo_flush_o (fifo_flush),
        .flush_stb_o  (flush_stb),
        .dma_en_o     (dma_en),
        .sts_o        (sts),
        .fld_irq_o    (fld_irq),
        .frm_irq_o    (frm_irq),
        .vert_irq_o   (vert_irq)
    );
endmodule

// File: tb/sim_vcap_sync_gate.sv
module sim_vcap_sync_gate;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        src_ext = 1'b0, eav_stb = 1'b0, f_bit = 1'b0, v_bit = 1'b0;
    logic        ext_vs = 1'b0, ext_fld = 1'b0;
    logic        blk_cap = 1'b0, fld_inv = 1'b0, vrst_sel = 1'b0;
    logic [2:0]  sts_clr = 3'b000;
    logic        fifo_flush, flush_stb, dma_en, fld_irq, frm_irq, vert_irq;
    logic [2:0]  sts;
    logic [11:0] vcount;

    int n_chk = 0;
    int n_fail = 0;
    logic irq_seen = 1'b0;
    logic done = 1'b0;

    always #5 clk = ~clk;

    vcap_sync_gate u0 (
        .clk(clk), .rst_n(rst_n), .src_ext(src_ext), .eav_stb(eav_stb),
        .f_bit(f_bit), .v_bit(v_bit), .ext_vs(ext_vs), .ext_fld(ext_fld),
        .blk_cap(blk_cap), .fld_inv(fld_inv), .vrst_sel(vrst_sel),
        .sts_clr(sts_clr), .fifo_flush(fifo_flush), .flush_stb(flush_stb),
        .dma_en(dma_en), .sts(sts), .fld_irq(fld_irq), .frm_irq(frm_irq),
        .vert_irq(vert_irq), .vcount(vcount)
    );

    always @(negedge clk) if (fld_irq || frm_irq || vert_irq) irq_seen = 1'b1;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic line(input logic v, input logic f);
        @(negedge clk); eav_stb = 1'b1; v_bit = v; f_bit = f;
        @(negedge clk); eav_stb = 1'b0;
    endtask

    task automatic clr_sts(input logic [2:0] m);
        @(negedge clk); sts_clr = m;
        @(negedge clk); sts_clr = 3'b000;
    endtask

    task automatic t_reset;
        chk("R4 reset dma_en", dma_en, 0);
        chk("R7 reset sts", sts, 0);
        chk("R8 reset vcount", vcount, 0);
        chk("R1 reset fifo_flush", fifo_flush, 0);
    endtask

    task automatic t_frame;
        line(1, 0);
        chk("R12 vert_irq at blank start", vert_irq, 1);
        chk("R9 vcount reset at blank start", vcount, 0);
        chk("R6 no fld_irq without field start", fld_irq, 0);
        line(1, 0);
        line(0, 0);
        chk("R4 dma_en at first field-1 start", dma_en, 1);
        line(0, 0); line(0, 0);
        chk("R8 vcount counts lines", vcount, 4);
        line(1, 1);
        chk("R6 field1 complete sts", sts, 3'b001);
        chk("R6 field1 fld_irq", fld_irq, 1);
        chk("R6 field1 no frm_irq", frm_irq, 0);
        line(0, 1);
        line(1, 0);
        chk("R6 frame complete sts", sts, 3'b111);
        chk("R6 frame frm_irq", frm_irq, 1);
    endtask

    task automatic t_w1c;
        clr_sts(3'b011);
        chk("R7 partial clear", sts, 3'b100);
        line(0, 0);
        @(negedge clk); eav_stb = 1'b1; v_bit = 1'b1; f_bit = 1'b0; sts_clr = 3'b001;
        @(negedge clk); eav_stb = 1'b0; sts_clr = 3'b000;
        chk("R7 set wins over clear", sts, 3'b101);
        clr_sts(3'b111);
        chk("R7 full clear", sts, 0);
    endtask

    task automatic t_block;
        @(negedge clk); blk_cap = 1'b1;
        @(negedge clk);
        chk("R1 fifo_flush on block", fifo_flush, 1);
        chk("R1 dma_en off on block", dma_en, 0);
        chk("R10 flush_stb pulse", flush_stb, 1);
        @(negedge clk);
        chk("R10 flush_stb one cycle", flush_stb, 0);
        chk("R1 fifo_flush held", fifo_flush, 1);
        irq_seen = 1'b0;
        line(0, 0); line(0, 0); line(1, 1); line(0, 1); line(0, 1);
        line(1, 0); line(0, 0); line(0, 0);
        chk("R2 status frozen while blocked", sts, 0);
        chk("R3 no interrupts while blocked", irq_seen, 0);
        chk("R1 dma_en low while blocked", dma_en, 0);
        @(negedge clk); blk_cap = 1'b0;
        @(negedge clk);
        chk("R4 dma_en low after release", dma_en, 0);
        line(1, 1);
        chk("R6 status resumes after release", sts, 3'b001);
        line(0, 1);
        chk("R4 no enable on field-2 start", dma_en, 0);
        line(1, 0);
        line(0, 0);
        chk("R4 enable on next field-1 start", dma_en, 1);
        clr_sts(3'b111);
    endtask

    task automatic t_inv;
        @(negedge clk); fld_inv = 1'b1;
        line(1, 1);
        clr_sts(3'b111);
        line(0, 1);
        line(1, 0);
        chk("R5 inverted raw 1 is field 1", sts, 3'b001);
        chk("R5 no frm_irq for field 1", frm_irq, 0);
        line(0, 0);
        line(1, 1);
        chk("R5 inverted raw 0 is field 2", sts, 3'b111);
        chk("R5 frm_irq for field 2", frm_irq, 1);
        clr_sts(3'b111);
        @(negedge clk); fld_inv = 1'b0;
    endtask

    task automatic t_vrst_end;
        @(negedge clk); vrst_sel = 1'b1;
        line(1, 0);
        line(0, 0);
        chk("R9 reset at blank end when sel=1", vcount, 0);
        line(0, 0);
        line(1, 0);
        chk("R9 no reset at blank start when sel=1", vcount, 2);
        clr_sts(3'b111);
        @(negedge clk); vrst_sel = 1'b0;
    endtask

    task automatic t_sat;
        line(0, 0);
        chk("R9 no reset at blank end when sel=0", vcount, 3);
        for (int i = 0; i < 4100; i++) line(0, 0);
        chk("R8 saturates at 4095", vcount, 12'hFFF);
        line(1, 0);
        chk("R9 reset after saturation", vcount, 0);
        clr_sts(3'b111);
    endtask

    task automatic t_ext;
        @(negedge clk); src_ext = 1'b1;
        line(1, 0); line(1, 0);
        chk("R11 strobes count in ext mode", vcount, 2);
        @(negedge clk); ext_vs = 1'b1;
        @(negedge clk);
        chk("R11 ext_vs rise is blank start", vert_irq, 1);
        chk("R11 vcount reset on ext rise", vcount, 0);
        @(negedge clk); ext_fld = 1'b1; ext_vs = 1'b0;
        @(negedge clk);
        @(negedge clk); ext_vs = 1'b1;
        @(negedge clk);
        chk("R11 ext field 2 completes frame", sts, 3'b110);
        chk("R11 ext frm_irq", frm_irq, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_frame();
        t_w1c();
        t_block();
        t_inv();
        t_vrst_end();
        t_sat();
        t_ext();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule